// File: doc/BRIEF.md
# Video Line and Row Decimator

This block shrinks a captured video stream by removing pixels inside each line and whole lines inside each frame. Pixels arrive one per cycle when `in_valid` is high, with `in_sol` on the first pixel of every line and `in_sof` on the first pixel of every frame. A pixel carrying `in_sof` also starts a line, whether or not `in_sol` is set. Pixels that survive leave one cycle later on the output stream, unchanged. The output start markers are moved so that they sit on the first pixel that survives.

Each axis works in units of two or four elements: columns for the horizontal axis, rows for the vertical axis. A shared size bit picks two or four for both axes. An axis has its own enable, its own mode bit and its own 8-bit count N:
- **Mode 0** repeats the pattern "keep N units, then drop one unit".
- **Mode 1** repeats the pattern "drop N units, then keep one unit".

The horizontal pattern starts again at every line. The vertical pattern starts again at every frame. The configuration inputs are captured only on a start-of-frame pixel, so the settings never change part way through a frame.

Top module: `video_decimator`

## Requirements
- R1: With both enables low, every valid input pixel appears on the output exactly one cycle later, with the same data, the same `out_sol` and the same `out_sof`.
- R2: With `cfg_h_en`=1 and `cfg_h_mode`=0, unit index k = floor(p/U) mod (N+1) is computed for pixel position p counted from 0 at each line start. The pixel is kept when k < N.
- R3: With `cfg_h_en`=1 and `cfg_h_mode`=1, the same index is used, and the pixel is kept only when k = N. As a result, the first pixel of every line is dropped.
- R4: With `cfg_v_en`=1, the R2 rule (`cfg_v_mode`=0) or the R3 rule (`cfg_v_mode`=1) is applied to the line index. The line index counts from 0 at each start-of-frame and uses `cfg_v_count`. A dropped line produces no output at all, including its start marker.
- R5: `cfg_unit4`=0 sets U=2 and `cfg_unit4`=1 sets U=4, for both axes.
- R6: A count value of 0 behaves exactly like a count of 1.
- R7: Configuration inputs are sampled only on a valid pixel with `in_sof`=1. That pixel already uses the new values. Changes made during a frame have no effect until the next start-of-frame.
- R8: `out_sol` is high on the first kept pixel of each line. `out_sof` is high on the first kept pixel of each frame, and that pixel also carries `out_sol`.
- R9: After reset, `out_valid`, `out_sol` and `out_sof` are low, and both axes are disabled until the first start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_h_en | input | 1 | Horizontal decimation enable |
| cfg_h_mode | input | 1 | Horizontal pattern: 0 keep-N-drop-1, 1 drop-N-keep-1 |
| cfg_v_en | input | 1 | Vertical decimation enable |
| cfg_v_mode | input | 1 | Vertical pattern, same encoding as horizontal |
| cfg_unit4 | input | 1 | Unit size: 0 = 2 elements, 1 = 4 elements |
| cfg_h_count | input | 8 | Horizontal unit count N |
| cfg_v_count | input | 8 | Vertical unit count N |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame |
| in_data | input | DATA_W | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_sol | output | 1 | First kept pixel of a line |
| out_sof | output | 1 | First kept pixel of a frame |
| out_data | output | DATA_W | Output pixel |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle passthrough when both axes are off;
- the absence of any output without an input one cycle earlier;
- silence during a dropped row;
- the first pixel of a line being dropped in horizontal mode 1, and a frame's first pixel surviving when both patterns start in their keep phase;
- the pairing of the frame marker with the line marker.

Other behaviour can only be shown by the bench's whole-frame scenarios:
- the exact keep/drop sequence over many units;
- the wrap of the pattern period and the zero-count rule;
- marker relocation onto later pixels;
- the rule that configuration changes wait for the next frame.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int CNT_W = 8;

  typedef struct packed {
    logic             h_en;
    logic             h_mode;
    logic             v_en;
    logic             v_mode;
    logic             unit4;
    logic [CNT_W-1:0] h_cnt;
    logic [CNT_W-1:0] v_cnt;
  } dec_cfg_t;

  // Count of zero is handled as one.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  // Index of the last element inside one unit.
  function automatic logic [1:0] unit_last(input logic unit4);
    return unit4 ? 2'd3 : 2'd1;
  endfunction

  // Keep decision for unit index k within a period of n+1 units.
  function automatic logic phase_keep(input logic mode,
                                      input logic [CNT_W-1:0] k,
                                      input logic [CNT_W-1:0] n);
    return mode ? (k == n) : (k < n);
  endfunction

endpackage

// File: rtl/dec_cfg_shadow.sv
module dec_cfg_shadow
  import dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  dec_cfg_t cfg_in,
  output dec_cfg_t cfg_eff
);

  dec_cfg_t shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= cfg_in;
  end

  // The frame-start pixel already sees the new settings.
  assign cfg_eff = load ? cfg_in : shadow_q;

endmodule

// File: rtl/dec_pattern.sv
module dec_pattern
  import dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             en,
  input  logic             mode,
  input  logic             unit4,
  input  logic [CNT_W-1:0] count,
  output logic             keep
);

  logic [1:0]       pix_q;
  logic [CNT_W-1:0] unit_q;
  logic [1:0]       cur_pix;
  logic [CNT_W-1:0] cur_unit;
  logic [CNT_W-1:0] n_eff;
  logic             unit_end;

  assign n_eff    = eff_count(count);
  assign cur_pix  = restart ? 2'd0 : pix_q;
  assign cur_unit = restart ? '0 : unit_q;
  assign unit_end = (cur_pix == unit_last(unit4));
  assign keep     = !en || phase_keep(mode, cur_unit, n_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= 2'd0;
      unit_q <= '0;
    end else if (step) begin
      if (unit_end) begin
        pix_q  <= 2'd0;
        unit_q <= (cur_unit >= n_eff) ? '0 : CNT_W'(cur_unit + 1'b1);
      end else begin
        pix_q  <= cur_pix + 2'd1;
        unit_q <= cur_unit;
      end
    end
  end

endmodule

// File: rtl/dec_marker.sv
module dec_marker (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic sol,
  input  logic sof,
  input  logic emit,
  output logic mark_sol,
  output logic mark_sof
);

  logic sol_pend_q;
  logic sof_pend_q;

  assign mark_sol = (valid && (sol || sof)) || sol_pend_q;
  assign mark_sof = (valid && sof) || sof_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sol_pend_q <= 1'b0;
      sof_pend_q <= 1'b0;
    end else if (emit) begin
      sol_pend_q <= 1'b0;
      sof_pend_q <= 1'b0;
    end else if (valid) begin
      sol_pend_q <= mark_sol;
      sof_pend_q <= mark_sof;
    end
  end

endmodule

// File: rtl/video_decimator.sv
module video_decimator
  import dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_h_en,
  input  logic              cfg_h_mode,
  input  logic              cfg_v_en,
  input  logic              cfg_v_mode,
  input  logic              cfg_unit4,
  input  logic [CNT_W-1:0]  cfg_h_count,
  input  logic [CNT_W-1:0]  cfg_v_count,
  input  logic              in_valid,
  input  logic              in_sol,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sol,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_data
);

  dec_cfg_t cfg_live;
  dec_cfg_t cfg_eff;

  logic frame_load;
  logic line_start;
  logic eff_h_en, eff_h_mode, eff_v_en, eff_v_mode;
  logic h_keep, v_keep;
  logic row_keep_q, row_keep_now;
  logic emit;
  logic mark_sol, mark_sof;

  assign cfg_live = '{h_en: cfg_h_en, h_mode: cfg_h_mode, v_en: cfg_v_en,
                      v_mode: cfg_v_mode, unit4: cfg_unit4,
                      h_cnt: cfg_h_count, v_cnt: cfg_v_count};

  assign frame_load = in_valid && in_sof;
  assign line_start = in_valid && (in_sol || in_sof);

  dec_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_load),
    .cfg_in(cfg_live), .cfg_eff(cfg_eff)
  );

  assign eff_h_en   = cfg_eff.h_en;
  assign eff_h_mode = cfg_eff.h_mode;
  assign eff_v_en   = cfg_eff.v_en;
  assign eff_v_mode = cfg_eff.v_mode;

  dec_pattern u_hpat (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .restart(line_start),
    .en(eff_h_en), .mode(eff_h_mode), .unit4(cfg_eff.unit4),
    .count(cfg_eff.h_cnt), .keep(h_keep)
  );

  dec_pattern u_vpat (
    .clk(clk), .rst_n(rst_n), .step(line_start), .restart(frame_load),
    .en(eff_v_en), .mode(eff_v_mode), .unit4(cfg_eff.unit4),
    .count(cfg_eff.v_cnt), .keep(v_keep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          row_keep_q <= 1'b1;
    else if (line_start) row_keep_q <= v_keep;
  end

  assign row_keep_now = line_start ? v_keep : row_keep_q;
  assign emit         = in_valid && h_keep && row_keep_now;

  dec_marker u_marker (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .sol(in_sol), .sof(in_sof),
    .emit(emit), .mark_sol(mark_sol), .mark_sof(mark_sof)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      out_sol   <= emit && mark_sol;
      out_sof   <= emit && mark_sof;
      if (emit) out_data <= in_data;
    end
  end

endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sol,
  input logic              in_sof,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_sol,
  input logic              out_sof,
  input logic [DATA_W-1:0] out_data,
  input logic              eff_h_en,
  input logic              eff_h_mode,
  input logic              eff_v_en,
  input logic              eff_v_mode,
  input logic              row_keep_now
);

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !eff_h_en && !eff_v_en |=> out_valid && out_data == $past(in_data)); // R1

  AST_H_MODE1_FIRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_sol || in_sof) && eff_h_en && eff_h_mode |=> !out_valid); // R3

  AST_ROW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !row_keep_now |=> !out_valid); // R4

  AST_FRAME_START_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && !(eff_h_en && eff_h_mode) && !(eff_v_en && eff_v_mode)
    |=> out_valid && out_sof && out_sol); // R8

  AST_SOF_WITH_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid && out_sol); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R9

endmodule

bind video_decimator dec_checker #(.DATA_W(DATA_W)) u_dec_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
  .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
  .out_sol(out_sol), .out_sof(out_sof), .out_data(out_data),
  .eff_h_en(eff_h_en), .eff_h_mode(eff_h_mode), .eff_v_en(eff_v_en),
  .eff_v_mode(eff_v_mode), .row_keep_now(row_keep_now)
);

// File: tb/test_video_decimator.sv
`timescale 1ns/1ps
module test_video_decimator;

  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_h_en = 0, cfg_h_mode = 0, cfg_v_en = 0, cfg_v_mode = 0, cfg_unit4 = 0;
  logic [7:0] cfg_h_count = 0, cfg_v_count = 0;
  logic in_valid = 0, in_sol = 0, in_sof = 0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sol, out_sof;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk; // 125 MHz

  video_decimator #(.DATA_W(DW)) i_video_decimator (
    .clk(clk), .rst_n(rst_n), .cfg_h_en(cfg_h_en), .cfg_h_mode(cfg_h_mode),
    .cfg_v_en(cfg_v_en), .cfg_v_mode(cfg_v_mode), .cfg_unit4(cfg_unit4),
    .cfg_h_count(cfg_h_count), .cfg_v_count(cfg_v_count),
    .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW+1:0] got[$];
  logic [DW+1:0] exp_q[$];

  typedef struct packed {
    logic       h_en, h_mode, v_en, v_mode, unit4;
    logic [7:0] hc, vc, lines, ppl;
    logic       gap;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0, 8'd0, 8'd3,  8'd6,  1'b0, 4'd1}, // R1 passthrough
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd2, 8'd0, 8'd2,  8'd16, 1'b0, 4'd2}, // R2 keep 2 drop 1
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd2, 8'd0, 8'd2,  8'd16, 1'b0, 4'd3}, // R3 drop 2 keep 1
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 8'd1, 8'd0, 8'd2,  8'd16, 1'b0, 4'd5}, // R5 four-wide units
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0, 8'd2, 8'd10, 8'd4,  1'b0, 4'd4}, // R4 rows keep 2 drop 1
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 8'd0, 8'd1, 8'd12, 8'd3,  1'b0, 4'd8}, // R8 sof moves to row 4
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd0, 8'd0, 8'd2,  8'd12, 1'b0, 4'd6}, // R6 count zero
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 8'd3, 8'd0, 8'd8,  8'd18, 1'b1, 4'd4}, // R4 both axes with gaps
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 8'd3, 8'd0, 8'd2,  8'd40, 1'b1, 4'd3}, // R3 with gaps
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0, 8'd0, 8'd9,  8'd2,  1'b0, 4'd6}  // R6 vertical count zero
  };

  always @(negedge clk)
    if (rst_n && out_valid) got.push_back({out_sof, out_sol, out_data});

  function automatic bit mdl_keep(bit en, bit mode, bit u4, int cnt, int idx);
    int u = u4 ? 4 : 2;
    int n = (cnt == 0) ? 1 : cnt;
    int k;
    if (!en) return 1'b1;
    k = (idx / u) % (n + 1);
    return mode ? (k == n) : (k < n);
  endfunction

  task automatic build_expected(int lines, int ppl);
    bit first_f = 1;
    for (int l = 0; l < lines; l++) begin
      bit first_l = 1;
      if (!mdl_keep(cfg_v_en, cfg_v_mode, cfg_unit4, int'(cfg_v_count), l)) continue;
      for (int p = 0; p < ppl; p++) begin
        if (!mdl_keep(cfg_h_en, cfg_h_mode, cfg_unit4, int'(cfg_h_count), p)) continue;
        exp_q.push_back({first_f, first_l, 8'(l), 8'(p)});
        first_f = 0;
        first_l = 0;
      end
    end
  endtask

  task automatic send_frame(int lines, int ppl, bit gap, bit mid_change);
    int n = 0;
    for (int l = 0; l < lines; l++) begin
      if (mid_change && l == 1) begin
        cfg_h_en = 1; cfg_h_mode = 1; cfg_h_count = 8'd1;
      end
      for (int p = 0; p < ppl; p++) begin
        @(negedge clk);
        in_valid = 1; in_sol = (p == 0); in_sof = (p == 0 && l == 0);
        in_data = {8'(l), 8'(p)};
        n++;
        if (gap && (n % 3 == 0)) begin
          @(negedge clk);
          in_valid = 0; in_sol = 0; in_sof = 0; in_data = 16'hDEAD;
        end
      end
      @(negedge clk);
      in_valid = 0; in_sol = 0; in_sof = 0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(int req, string what);
    checks++;
    if (got.size() != exp_q.size()) begin
      fails++;
      $display("FAIL R%0d %s: count actual %0d expected %0d", req, what, got.size(), exp_q.size());
    end
    for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
      checks++;
      if (got[i] !== exp_q[i]) begin
        fails++;
        $display("FAIL R%0d %s: item %0d actual %h expected %h", req, what, i, got[i], exp_q[i]);
      end
    end
    got.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs quiet in and after reset
    checks++;
    if (out_valid !== 1'b0 || out_sol !== 1'b0 || out_sof !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: actual %b%b%b expected 000", out_valid, out_sol, out_sof);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 idle after reset: actual %b expected 0", out_valid);
    end

    for (int v = 0; v < NV; v++) begin
      cfg_h_en = VECS[v].h_en; cfg_h_mode = VECS[v].h_mode;
      cfg_v_en = VECS[v].v_en; cfg_v_mode = VECS[v].v_mode;
      cfg_unit4 = VECS[v].unit4;
      cfg_h_count = VECS[v].hc; cfg_v_count = VECS[v].vc;
      build_expected(int'(VECS[v].lines), int'(VECS[v].ppl));
      send_frame(int'(VECS[v].lines), int'(VECS[v].ppl), VECS[v].gap, 1'b0);
      compare(int'(VECS[v].req), $sformatf("vector %0d", v));
    end

    // R7: mid-frame change ignored, used from next frame on
    cfg_h_en = 0; cfg_h_mode = 0; cfg_v_en = 0; cfg_v_mode = 0; cfg_unit4 = 0;
    cfg_h_count = 0; cfg_v_count = 0;
    build_expected(3, 8);
    send_frame(3, 8, 1'b0, 1'b1);
    compare(7, "mid-frame change held off");
    build_expected(3, 8);
    send_frame(3, 8, 1'b0, 1'b0);
    compare(7, "change applied at next frame");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule